// File: doc/BRIEF.md
# Sector Erase Sequencer with Boot Lock

This block is the erase and write-permission controller of a 256 KiB flash array. The array is divided into seven sectors of unequal size. A command port accepts four operations: program a byte, erase one sector, erase the whole chip, and set the boot lock. The block translates a byte address into a sector index. It times every sector erase with an internal cycle counter, so the host needs no clock or timer of its own. While an erase runs, the block raises one enable line per sector.

The boot sector can be locked by a one-time command. Once locked, it is never erased or programmed. The only exception is while the override input (the high-voltage condition) is held. A whole-chip erase with the lock set quietly leaves the boot sector alone. A sector erase or a program aimed at the locked boot sector is refused with a one-cycle reject pulse. The lock bit is exported so the identification read path can return it on data bit 0.

A parameter selects bottom-boot or mirrored top-boot address decoding. Another parameter sets the erase time in clock cycles.

Top module: `sector_erase_seq`

## Requirements
- R1: With TOP_BOOT=0, `cmd_addr` maps to a sector index as follows: 00000-03FFF is 0 (boot), 04000-05FFF is 1, 06000-07FFF is 2, 08000-0FFFF is 3, 10000-1FFFF is 4, 20000-2FFFF is 5, 30000-3FFFF is 6. `erase_en` bit k enables sector k.
- R2: With TOP_BOOT=1, the decode is mirrored: 3C000-3FFFF is 0 (boot), 3A000-3BFFF is 1, 38000-39FFF is 2, 30000-37FFF is 3, 20000-2FFFF is 4, 10000-1FFFF is 5, 00000-0FFFF is 6.
- R3: `cmd_op` encodes the operation: 0 program, 1 sector erase, 2 chip erase, 3 set lock. An accepted sector erase raises `busy` on the next cycle. It then holds exactly one `erase_en` bit for ERASE_CYCLES cycles, and `busy` stays high for exactly that long.
- R4: With the lock clear, a chip erase enables sectors 0 through 6 in ascending order, ERASE_CYCLES each, with `busy` high for 7*ERASE_CYCLES cycles.
- R5: With the lock set and `override` low, a chip erase skips sector 0 without a reject: sectors 1 through 6 only, 6*ERASE_CYCLES busy cycles.
- R6: Operation 3 sets `boot_locked` on the following cycle. The bit never clears except through `rst_n`.
- R7: With the lock set and `override` low, a program or a sector erase that targets sector 0 produces a one-cycle `reject` the next cycle, with no `prog_go` and no erase. Other sectors are unaffected by the lock.
- R8: While `override` is high when the command is accepted, the boot sector can be erased or programmed despite the lock.
- R9: Every command presented while `busy` is high is ignored: no `prog_go`, no `reject`, no lock change, and the running sequence continues unchanged.
- R10: An idle program that is not refused produces a one-cycle `prog_go` on the cycle after the command.
- R11: `rst_n` low aborts any running erase. It clears `busy`, `erase_en` and the lock at once. An aborted erase must be reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts any operation |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 set lock |
| cmd_addr | input | 18 | Byte address of the command target |
| override | input | 1 | High-voltage condition; bypasses the boot lock while high |
| busy | output | 1 | High for the whole erase sequence |
| erase_en | output | 7 | One-hot enable of the sector being erased |
| prog_go | output | 1 | One-cycle pulse: program accepted |
| reject | output | 1 | One-cycle pulse: command refused by the boot lock |
| boot_locked | output | 1 | Lock state, for the identification read path |

## Verification
On every cycle, the assertions check the following:
- `erase_en` stays one-hot, and it matches `busy`.
- A running sector enable does not move mid-count.
- The boot enable only rises when the lock permitted it.
- Commands presented while busy give neither `prog_go` nor `reject`.
- The lock never falls outside reset.

Only the bench scenarios can show three further properties. The first is the address decode in both variants. The second is the exact erase length and sector order of a chip erase, with and without the lock. The third is the behaviour of an abort followed by a reissued erase.

// File: rtl/sector_erase_seq.sv
module sector_erase_seq #(
  parameter int ERASE_CYCLES = 4096,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [17:0] cmd_addr,
  input  logic        override,
  output logic        busy,
  output logic [6:0]  erase_en,
  output logic        prog_go,
  output logic        reject,
  output logic        boot_locked
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ERASE_CYCLES - 1);
  localparam logic [2:0] LAST_SEC = 3'd6;

  logic [2:0]    sec_q, tgt;
  logic [CW-1:0] cnt_q;
  logic          chip_q, lock_q;
  logic [17:0]   a;

  assign a = TOP_BOOT ? ~cmd_addr : cmd_addr;

  always_comb begin
    if (a[17:16] != 2'b00)  tgt = {1'b0, a[17:16]} + 3'd3;
    else if (a[15])         tgt = 3'd3;
    else if (!a[14])        tgt = 3'd0;
    else                    tgt = a[13] ? 3'd2 : 3'd1;
  end

  wire boot_ok = !lock_q || override;
  wire blocked = (tgt == 3'd0) && !boot_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      chip_q  <= 1'b0;
      sec_q   <= '0;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
      prog_go <= 1'b0;
      reject  <= 1'b0;
    end else begin
      prog_go <= 1'b0;
      reject  <= 1'b0;
      if (busy) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (chip_q && sec_q != LAST_SEC) begin
          sec_q <= sec_q + 3'd1;
          cnt_q <= CNT_LAST;
        end else begin
          busy   <= 1'b0;
          chip_q <= 1'b0;
        end
      end else if (cmd_valid) begin
        case (cmd_op)
          2'd0: if (blocked) reject <= 1'b1; else prog_go <= 1'b1;
          2'd1: if (blocked) reject <= 1'b1;
                else begin
                  busy  <= 1'b1;
                  sec_q <= tgt;
                  cnt_q <= CNT_LAST;
                end
          2'd2: begin
                  busy   <= 1'b1;
                  chip_q <= 1'b1;
                  sec_q  <= boot_ok ? 3'd0 : 3'd1;
                  cnt_q  <= CNT_LAST;
                end
          default: lock_q <= 1'b1;
        endcase
      end
    end
  end

  assign erase_en    = busy ? (7'd1 << sec_q) : 7'd0;
  assign boot_locked = lock_q;

  a_r3_onehot_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_en) && ((erase_en != 7'd0) == busy));

  a_r3_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> $stable(erase_en));

  a_r7_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_en[0]) |-> $past(boot_ok));

  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (!prog_go && !reject));

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_go && reject));
endmodule

// File: tb/sector_erase_seq_tb_top.sv
module sector_erase_seq_tb_top;
  localparam int E = 8;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, override = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [17:0] cmd_addr = '0;
  logic busy, prog_go, reject, boot_locked;
  logic busy_t, prog_go_t, reject_t, boot_locked_t;
  logic [6:0] erase_en, erase_en_t;

  int checks = 0, fails = 0;
  bit model_lock = 1'b0;

  always #5 clk = ~clk;

  sector_erase_seq #(.ERASE_CYCLES(E), .TOP_BOOT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .override(override), .busy(busy), .erase_en(erase_en),
    .prog_go(prog_go), .reject(reject), .boot_locked(boot_locked));

  sector_erase_seq #(.ERASE_CYCLES(E), .TOP_BOOT(1'b1)) dut_top_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .override(override), .busy(busy_t), .erase_en(erase_en_t),
    .prog_go(prog_go_t), .reject(reject_t), .boot_locked(boot_locked_t));

  function automatic int sec_bot(logic [17:0] ad);
    if (ad < 18'h04000) return 0;
    if (ad < 18'h06000) return 1;
    if (ad < 18'h08000) return 2;
    if (ad < 18'h10000) return 3;
    if (ad < 18'h20000) return 4;
    if (ad < 18'h30000) return 5;
    return 6;
  endfunction

  function automatic int sec_top(logic [17:0] ad);
    if (ad >= 18'h3C000) return 0;
    if (ad >= 18'h3A000) return 1;
    if (ad >= 18'h38000) return 2;
    if (ad >= 18'h30000) return 3;
    if (ad >= 18'h20000) return 4;
    if (ad >= 18'h10000) return 5;
    return 6;
  endfunction

  function automatic logic [6:0] erase_mask(int s);
    if (s == 0 && model_lock && !override) return 7'd0;
    return 7'd1 << s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [17:0] ad);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_erase(logic [1:0] op, logic [17:0] ad, logic [6:0] exp_mask,
                          logic [6:0] exp_top, string req);
    int per[7];
    int nbusy = 0, last = -1, guard = 0;
    bit ordered = 1'b1;
    logic [6:0] first_top;
    logic [6:0] seen = '0;
    for (int k = 0; k < 7; k++) per[k] = 0;
    issue(op, ad);
    first_top = erase_en_t;
    while ((busy || busy_t) && guard < 200) begin
      if (busy) nbusy++;
      for (int k = 0; k < 7; k++)
        if (erase_en[k]) begin
          per[k]++;
          seen[k] = 1'b1;
          if (k < last) ordered = 1'b0;
          last = k;
        end
      guard++;
      @(negedge clk);
    end
    chk(seen == exp_mask, req, seen, exp_mask);
    chk(nbusy == $countones(exp_mask) * E, req, nbusy, $countones(exp_mask) * E);
    chk(ordered, req, ordered, 1);
    for (int k = 0; k < 7; k++)
      if (exp_mask[k]) chk(per[k] == E, req, per[k], E);
    if (op == 2'd1) chk(first_top == exp_top, "R2 mirrored decode", first_top, exp_top);
  endtask

  task automatic do_prog(logic [17:0] ad, bit exp_rej, string req);
    issue(2'd0, ad);
    chk(prog_go == !exp_rej, req, prog_go, !exp_rej);
    chk(reject == exp_rej, req, reject, exp_rej);
    @(negedge clk);
    chk(!prog_go && !reject, "R10 one-cycle pulse", {prog_go, reject}, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && erase_en == 0 && !boot_locked && !prog_go && !reject,
        "R11 reset state", {busy, erase_en, boot_locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: every bottom sector boundary, sector erase (R1, R3)
    do_erase(2'd1, 18'h03FFF, 7'h01, 7'h40, "R1 boot low edge");
    do_erase(2'd1, 18'h04000, 7'h02, 7'h40, "R1 param1");
    do_erase(2'd1, 18'h07FFF, 7'h04, 7'h40, "R1 param2");
    do_erase(2'd1, 18'h08000, 7'h08, 7'h40, "R1 main1");
    do_erase(2'd1, 18'h3C000, 7'h40, 7'h01, "R3 main4 / R2 top boot");
    do_erase(2'd1, 18'h3A000, 7'h40, 7'h02, "R2 top param1");
    do_erase(2'd1, 18'h39FFF, 7'h40, 7'h04, "R2 top param2");

    do_erase(2'd2, 18'h00555, 7'h7F, 7'h7F, "R4 chip erase unlocked");
    do_prog(18'h00010, 1'b0, "R10 program unlocked boot");

    // Lock (R6)
    issue(2'd3, 18'h00555);
    model_lock = 1'b1;
    chk(boot_locked && boot_locked_t, "R6 lock set", boot_locked, 1);

    do_erase(2'd2, 18'h00555, 7'h7E, 7'h7E, "R5 chip erase locked skips boot");
    issue(2'd1, 18'h00100);
    chk(reject && !busy, "R7 locked sector erase rejected", {reject, busy}, 2);
    repeat (E + 2) @(negedge clk);
    do_prog(18'h03FFF, 1'b1, "R7 locked boot program");
    do_prog(18'h04000, 1'b0, "R7 other sector program");

    override = 1'b1;
    do_prog(18'h00020, 1'b0, "R8 override program");
    do_erase(2'd1, 18'h00020, 7'h01, 7'h40, "R8 override erase");
    do_erase(2'd2, 18'h00555, 7'h7F, 7'h7F, "R8 override chip erase");
    override = 1'b0;
    do_prog(18'h00020, 1'b1, "R8 lock resumes after override");
    chk(boot_locked, "R6 lock sticky", boot_locked, 1);

    // Random mix (R1, R7, R10)
    for (int i = 0; i < 40; i++) begin
      logic [17:0] ad;
      int op;
      ad = 18'($urandom);
      op = $urandom_range(0, 1);
      override = ($urandom_range(0, 3) == 0);
      if (op == 0)
        do_prog(ad, (sec_bot(ad) == 0) && model_lock && !override, "R7 random program");
      else
        do_erase(2'd1, ad, erase_mask(sec_bot(ad)),
                 (sec_top(ad) == 0 && model_lock && !override) ? 7'd0 : (7'd1 << sec_top(ad)),
                 "R1 random sector erase");
    end
    override = 1'b0;

    // Busy ignores commands (R9)
    rst_n = 1'b0; model_lock = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(2'd2, 18'h00555);
    repeat (3) @(negedge clk);
    issue(2'd0, 18'h10000);
    chk(!prog_go && !reject, "R9 program ignored while busy", {prog_go, reject}, 0);
    issue(2'd3, 18'h00555);
    chk(!boot_locked, "R9 lock ignored while busy", boot_locked, 0);
    chk(erase_en == 7'h01, "R9 sequence undisturbed", erase_en, 7'h01);
    while (busy) @(negedge clk);
    chk(!boot_locked, "R9 lock still clear after erase", boot_locked, 0);

    // Abort by reset (R11)
    issue(2'd3, 18'h0);
    model_lock = 1'b1;
    issue(2'd2, 18'h00555);
    repeat (E + 3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && erase_en == 0 && !boot_locked, "R11 abort", {busy, erase_en, boot_locked}, 0);
    @(negedge clk); rst_n = 1'b1;
    model_lock = 1'b0;
    @(negedge clk);
    chk(!busy, "R11 stays idle after abort", busy, 0);
    do_erase(2'd1, 18'h00000, 7'h01, 7'h40, "R11 reissued erase");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule